// File: doc/BRIEF.md
# PWM Timer Channel Control and Status

This block is one channel of a motor-control PWM timer. A CPU reaches it over a simple bus with an address, read and write strobes and byte-wide data. An 8-bit control/status register holds a counter start bit, a 3-bit clock-select code, an interrupt enable and a compare-match flag. A prescaler divides the system clock by a power of two picked by the select code, and an up-counter advances once per prescaled pulse. When the counter reaches the value held in the cycle (period) register, the flag is set. On the next count the counter wraps to zero.

The flag drives an interrupt request whenever the enable is set. Software clears the flag with a two-step handshake: it first reads the flag as 1, then writes 0 to that bit. A DMA transfer started by the match can also clear the flag, provided the transfer signals that clearing is allowed. If a new match lands in the same cycle as any clear, the flag stays set.

Top module: `pwm_chan_ctrl`

## Requirements
- R1: After reset the status register (address 0) reads 0xC0, the counter (address 2) reads 0, the cycle register (address 1) reads 0xFF and irq_o is low.
- R2: Bits 7 and 6 of the status register always read 1, whatever was written to them.
- R3: Status register layout at address 0: bit 5 interrupt enable, bit 4 match flag, bit 3 start, bits 2:0 clock select. Bits 5, 3 and 2:0 read back the last value written. Address 1 is the read/write cycle register. Address 2 returns the counter, and writes to it are ignored.
- R4: The flag becomes 1 in the same cycle that the counter advances to a value equal to the cycle register, and not before.
- R5: A write to address 0 with bit 4 at 0 clears the flag only if a read of address 0 returned bit 4 as 1 and no write to address 0 has come since. A write with bit 4 at 1, or a write without that earlier read, leaves the flag set.
- R6: A one-cycle pulse on dma_ack_i with dma_clr_en_i high clears the flag. The same pulse with dma_clr_en_i low leaves the flag unchanged.
- R7: If a match and a clear fall in the same cycle, the flag ends at 1.
- R8: irq_o is high exactly when both the flag and the enable are 1, and it stays high until the flag is cleared.
- R9: With start at 0 the counter holds its value. The prescaler restarts from zero each time the counter is started.
- R10: Clock-select code k makes the counter advance once every 2^k clocks. After the edge that writes start=1, the counter has gained floor(N/2^k) after N further edges.
- R11: When the counter equals the cycle register, the next count enable loads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address (0 status, 1 cycle, 2 counter) |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| dma_ack_i | input | 1 | DMA transfer completion pulse |
| dma_clr_en_i | input | 1 | Qualifies dma_ack_i as a flag clear |
| irq_o | output | 1 | Compare-match interrupt request |

## Verification
On every cycle, the assertions check that a match always leaves the flag set, and that a clear by DMA takes effect when no match competes with it. They also check that an unarmed write or a write of 1 never drops the flag, that a stopped counter holds its value, that the counter steps by exactly one or wraps to zero, and that the prescaled pulses are spaced apart. The bench scenarios are what show the exact cycle counts. These cover the division ratio for each select code, the cycle in which the flag first becomes visible, and the full read-then-write clear sequence as seen on the bus. They also cover reserved-bit readback, the read-only counter address and the interrupt level across the enable and clear paths.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SEL_W  = 3;

  localparam logic [ADDR_W-1:0] A_CSR = 2'd0;
  localparam logic [ADDR_W-1:0] A_CYC = 2'd1;
  localparam logic [ADDR_W-1:0] A_CNT = 2'd2;

  // bit positions in the status register
  localparam int unsigned B_IE   = 5;
  localparam int unsigned B_FLAG = 4;
  localparam int unsigned B_CST  = 3;

  typedef struct packed {
    logic             ie;
    logic             flag;
    logic             cst;
    logic [SEL_W-1:0] sel;
  } csr_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned NDIV  = 1 << SEL_W;
  localparam int unsigned PRE_W = NDIV - 1;

  logic [PRE_W-1:0] pre_q;
  logic [NDIV-1:0]  tick_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (!run_i) pre_q <= '0;
    else             pre_q <= pre_q + PRE_W'(1);
  end

  // code g fires when the low g bits are all ones
  for (genvar g = 0; g < NDIV; g++) begin : g_tap
    if (g == 0) begin : g_div1
      assign tick_vec[g] = 1'b1;
    end else begin : g_divn
      assign tick_vec[g] = &pre_q[g-1:0];
    end
  end

  assign tick_o = run_i & tick_vec[sel_i];

  p_tick_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_o && sel_i != '0) |=> (sel_i != $past(sel_i) || !tick_o));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cyc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  assign cnt_nxt = (cnt_q == cyc_i) ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_nxt;
  end

  // match reported on the step that lands on the cycle value
  assign match_o = tick_i && (cnt_nxt == cyc_i);
  assign cnt_o   = cnt_q;

  p_hold_stopped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q));
  p_step_one_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q != cyc_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  p_wrap_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q == cyc_i) |=> cnt_q == '0);
endmodule

// File: rtl/pwm_csr.sv
module pwm_csr
  import pwm_chan_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [5:0] wdata_i,
  input  logic       set_i,
  input  logic       dma_clr_i,
  output csr_t       csr_o
);
  csr_t csr_q;
  logic arm_q;
  logic sw_clr;

  // armed by a read that saw the flag, disarmed by any status write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                arm_q <= 1'b0;
    else if (wr_i)              arm_q <= 1'b0;
    else if (rd_i && csr_q.flag) arm_q <= 1'b1;
  end

  assign sw_clr = wr_i && !wdata_i[B_FLAG] && arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q <= '0;
    end else begin
      if (wr_i) begin
        csr_q.ie  <= wdata_i[B_IE];
        csr_q.cst <= wdata_i[B_CST];
        csr_q.sel <= wdata_i[SEL_W-1:0];
      end
      if (set_i)                    csr_q.flag <= 1'b1;  // set wins
      else if (sw_clr || dma_clr_i) csr_q.flag <= 1'b0;
    end
  end

  assign csr_o = csr_q;

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> csr_q.flag);
  p_dma_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_clr_i && !set_i) |=> !csr_q.flag);
  p_wr1_keeps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_q.flag && wr_i && wdata_i[B_FLAG] && !dma_clr_i) |=> csr_q.flag);
  p_unarmed_keeps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_q.flag && wr_i && !arm_q && !dma_clr_i) |=> csr_q.flag);
endmodule

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl
  import pwm_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 8  // at most DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              dma_ack_i,
  input  logic              dma_clr_en_i,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] CYC_RST = '1;

  csr_t             csr;
  logic             csr_wr, csr_rd, cyc_wr, dma_clr;
  logic             tick, match;
  logic [CNT_W-1:0] cyc_q, cnt;

  assign csr_wr  = wr_i && addr_i == A_CSR;
  assign csr_rd  = rd_i && addr_i == A_CSR;
  assign cyc_wr  = wr_i && addr_i == A_CYC;
  assign dma_clr = dma_ack_i && dma_clr_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cyc_q <= CYC_RST;
    else if (cyc_wr) cyc_q <= wdata_i[CNT_W-1:0];
  end

  pwm_csr u_csr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (csr_wr),
    .rd_i      (csr_rd),
    .wdata_i   (wdata_i[5:0]),
    .set_i     (match),
    .dma_clr_i (dma_clr),
    .csr_o     (csr)
  );

  pwm_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (csr.cst),
    .sel_i  (csr.sel),
    .tick_o (tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (csr.cst),
    .tick_i  (tick),
    .cyc_i   (cyc_q),
    .cnt_o   (cnt),
    .match_o (match)
  );

  always_comb begin
    unique case (addr_i)
      A_CSR:   rdata_o = {2'b11, csr};
      A_CYC:   rdata_o = DATA_W'(cyc_q);
      A_CNT:   rdata_o = DATA_W'(cnt);
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = csr.flag & csr.ie;

  p_irq_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !dma_clr && !csr_wr) |=> irq_o);
endmodule

// File: tb/tb_pwm_chan_ctrl.sv
`timescale 1ns/1ps
module tb_pwm_chan_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       dma_ack = 1'b0, dma_clr_en = 1'b0;
  logic       irq;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pwm_chan_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .dma_ack_i(dma_ack),
    .dma_clr_en_i(dma_clr_en), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // tasks are entered just after a falling edge
  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic dma_pulse(input logic en);
    dma_ack = 1'b1; dma_clr_en = en;
    @(negedge clk);
    dma_ack = 1'b0; dma_clr_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    bus_rd(2'd0, v); chk("R1 status", v, 8'hC0);
    bus_rd(2'd2, v); chk("R1 counter", v, 0);
    bus_rd(2'd1, v); chk("R1 cycle", v, 8'hFF);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_fields();
    logic [7:0] v;
    bus_wr(2'd0, 8'h37);
    bus_rd(2'd0, v); chk("R2 R3 fields", v, 8'hE7);
    chk("R8 irq without flag", irq, 0);
    bus_wr(2'd0, 8'h00);
    bus_rd(2'd0, v); chk("R2 reserved ones", v, 8'hC0);
    bus_wr(2'd1, 8'h5A);
    bus_rd(2'd1, v); chk("R3 cycle rw", v, 8'h5A);
    bus_wr(2'd2, 8'h33);
    bus_rd(2'd2, v); chk("R3 counter read-only", v, 0);
    bus_wr(2'd1, 8'hFF);
  endtask

  task automatic t_div(input int k);
    logic [7:0] c0, v, c1;
    int n;
    n = 4 * (1 << k) - 1;
    bus_rd(2'd2, c0);
    bus_wr(2'd0, 8'(8'h08 | k));
    repeat (n) @(negedge clk);
    bus_rd(2'd2, v); chk($sformatf("R10 div code %0d", k), v, 8'(c0 + 3));
    bus_wr(2'd0, 8'h00);
    bus_rd(2'd2, c1);
    repeat (10) @(negedge clk);
    bus_rd(2'd2, v); chk("R9 hold when stopped", v, c1);
  endtask

  task automatic t_match();
    logic [7:0] c0, v;
    bus_rd(2'd2, c0);
    bus_wr(2'd1, 8'(c0 + 2));
    bus_wr(2'd0, 8'h08);
    @(negedge clk);
    bus_rd(2'd0, v); chk("R4 flag not early", v[4], 0);
    bus_rd(2'd0, v); chk("R4 flag on match", v[4], 1);
    bus_rd(2'd2, v); chk("R11 wrap to zero", v, 0);
    bus_rd(2'd2, v); chk("R11 count after wrap", v, 1);
    chk("R8 no irq with enable off", irq, 0);
    bus_wr(2'd0, 8'h10);
    bus_rd(2'd0, v); chk("R5 write of one keeps flag", v, 8'hD0);
    bus_wr(2'd0, 8'h10);
    bus_wr(2'd0, 8'h00);
    bus_rd(2'd0, v); chk("R5 unarmed write keeps flag", v, 8'hD0);
    bus_wr(2'd0, 8'h00);
    bus_rd(2'd0, v); chk("R5 armed write clears", v, 8'hC0);
  endtask

  task automatic t_irq();
    logic [7:0] c;
    bus_rd(2'd2, c);
    bus_wr(2'd1, 8'(c + 1));
    bus_wr(2'd0, 8'h28);
    @(negedge clk);
    chk("R8 irq on match", irq, 1);
    bus_wr(2'd0, 8'h30);
    repeat (5) @(negedge clk);
    chk("R8 irq held", irq, 1);
    dma_pulse(1'b0);
    chk("R6 ack without clear enable", irq, 1);
  endtask

  task automatic t_set_wins();
    logic [7:0] c, v;
    bus_rd(2'd2, c);
    bus_wr(2'd1, 8'(c + 2));
    bus_wr(2'd0, 8'h28);
    @(negedge clk);
    dma_pulse(1'b1);   // clear lands on the match edge
    bus_rd(2'd0, v); chk("R7 set beats clear", v, 8'hF8);
    bus_wr(2'd0, 8'h30);
    dma_pulse(1'b1);
    chk("R6 dma clear drops irq", irq, 0);
    bus_rd(2'd0, v); chk("R6 dma clear", v, 8'hE0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    for (int k = 0; k < 4; k++) t_div(k);
    t_match();
    t_irq();
    t_set_wins();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule